// File: doc/BRIEF.md
# Fast-Page DRAM Single-Word Controller

This block connects a synchronous host port to a 1M x 16 asynchronous fast-page-mode DRAM. A host request carries a write flag, a 20-bit word address, 16-bit write data and one enable per byte lane. The controller turns each request into one multiplexed row/column DRAM cycle and answers with a one-clock acknowledge. The upper ten address bits go out as the row while RAS is low. The lower ten go out as the column while the CAS strobes are low. Each byte lane has its own CAS strobe, and a strobe is pulsed only when its byte is enabled.

After reset the controller waits a parameterized pause. It then runs a series of CAS-before-RAS refreshes before it accepts any host access. From then on, a timer requests a refresh at a fixed interval. A pending refresh wins over a new host request, but an access that has already started always finishes first. Writes are always early writes: WE falls together with RAS, well before any CAS falls, and OE stays high, so the DRAM never drives its data pins during a write.

All phase lengths are clock-count parameters: RAS-to-CAS delay, CAS low time, precharge time and refresh RAS low time. The DRAM data bus appears as separate in, out and drive-enable signals so that the pad tristate can sit outside the block.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset every strobe is high and no acknowledge is given. The controller holds for WAKE_CYC cycles, then performs WAKE_REFS refreshes before any host access starts; host requests made meanwhile wait.
- R2: A refresh holds both CAS strobes low with RAS high for one cycle, then holds RAS and both CAS low for T_RAS cycles, then holds all strobes high for T_RP cycles. WE and OE stay high throughout.
- R3: Once the wake-up series is done, a refresh becomes pending every REF_INT cycles. At idle a pending refresh is started ahead of a waiting host request, and an access in progress is never interrupted.
- R4: An access accepted at a clock edge holds RAS low for T_RCD cycles with hostAddr[19:10] on the address pins. It then holds the enabled CAS strobes low for T_CAS cycles with hostAddr[9:0] on the address pins, while RAS stays low.
- R5: dramCasN[0] goes low in an access only if hostBe[0] is set, and it gates data bits 7:0. dramCasN[1] goes low only if hostBe[1] is set, and it gates bits 15:8.
- R6: During a write, dramWeN is low from the first RAS-low cycle through the last CAS-low cycle, so it is already low when CAS falls. dramOeN stays high, dramDqDrive is high and dramDqOut carries the write data.
- R7: During a read, dramOeN is low exactly in the CAS-low cycles and dramWeN stays high. hostRdata takes dramDqIn at the last CAS-low cycle for enabled lanes and reads zero on disabled lanes.
- R8: hostAck is high for exactly one cycle, the cycle after the CAS phase, with all strobes high. All strobes then stay high for T_RP cycles before the controller is idle again.
- R9: From acceptance until the controller returns to idle, changes on hostReq, hostWrite, hostAddr, hostWdata and hostBe have no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Access request, held until acknowledged |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 20 | Word address; [19:10] row, [9:0] column |
| hostWdata | input | 16 | Write data |
| hostBe | input | 2 | Byte enables; bit 0 = bits 7:0, bit 1 = bits 15:8 |
| hostAck | output | 1 | One-cycle completion pulse |
| hostRdata | output | 16 | Read data, valid with hostAck of a read |
| dramAddr | output | 10 | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 2 | Column strobes per lane, active low; bit 0 lower byte |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDqOut | output | 16 | Data toward the DRAM |
| dramDqIn | input | 16 | Data from the DRAM |
| dramDqDrive | output | 1 | Enables the data pad drivers toward the DRAM |

## Verification
An access sampled at edge k drives RAS low in the cycle right after edge k, with the row address. CAS falls T_RCD cycles later, hostAck rises T_RCD+T_CAS cycles after edge k, and the next request can be taken T_RP cycles after the acknowledge. A refresh spans 1+T_RAS+T_RP cycles. The reference model in the bench ages every operation by one per clock and derives the expected strobes, address, write data, acknowledge and read data from that age alone. Outputs are sampled on the falling edge, half a period after the register updates, so each comparison lands in the cycle the timeline names.

// File: rtl/fpdram_pkg.sv
package fpdram_pkg;

  typedef enum logic [2:0] {
    ST_WAKE, ST_IDLE, ST_ROW, ST_COL, ST_ACK, ST_PRE, ST_RCAS, ST_RRAS
  } fsm_state_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;     // capture host request fields
    logic selCol;   // drive column instead of row
    logic casOn;    // access CAS phase, gated per lane
    logic casAll;   // refresh: all lanes low
    logic capture;  // last CAS cycle of a read: latch data
  } dp_strobe_t;

endpackage

// File: rtl/fpdram_ctrl.sv
module fpdram_ctrl
  import fpdram_pkg::*;
#(
  parameter int WAKE_CYC  = 20000,
  parameter int REF_INT   = 1560,
  parameter int WAKE_REFS = 8,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       opWrite,
  output logic       ack,
  output logic       rasN,
  output logic       weN,
  output logic       oeN,
  output logic       dqDrive,
  output dp_strobe_t stb
);
  localparam int PH_MAX = (T_RCD > T_CAS ? T_RCD : T_CAS) > (T_RP > T_RAS ? T_RP : T_RAS)
                        ? (T_RCD > T_CAS ? T_RCD : T_CAS) : (T_RP > T_RAS ? T_RP : T_RAS);
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int WAKE_W = $clog2(WAKE_CYC + 1);
  localparam int REF_W  = $clog2(REF_INT + 1);
  localparam int RL_W   = $clog2(WAKE_REFS + 1);

  fsm_state_t state, nxt;
  logic [PH_W-1:0]   ph, phVal;
  logic              phLoad;
  logic [WAKE_W-1:0] wakeCnt;
  logic [REF_W-1:0]  refTimer;
  logic [RL_W-1:0]   refsLeft;
  logic              refPend, refFire, goRef, goAcc, ready;

  assign ready = (refsLeft == '0);

  always_comb begin
    nxt    = state;
    phLoad = 1'b0;
    phVal  = '0;
    goRef  = 1'b0;
    goAcc  = 1'b0;
    unique case (state)
      ST_WAKE: if (wakeCnt == WAKE_W'(WAKE_CYC - 1)) nxt = ST_IDLE;
      ST_IDLE: begin
        if (!ready || refPend) begin
          goRef = 1'b1;
          nxt   = ST_RCAS;
        end else if (hostReq) begin
          goAcc  = 1'b1;
          nxt    = ST_ROW;
          phLoad = 1'b1;
          phVal  = PH_W'(T_RCD - 1);
        end
      end
      ST_ROW: if (ph == '0) begin
        nxt    = ST_COL;
        phLoad = 1'b1;
        phVal  = PH_W'(T_CAS - 1);
      end
      ST_COL: if (ph == '0) nxt = ST_ACK;
      ST_ACK: begin
        nxt    = ST_PRE;
        phLoad = 1'b1;
        phVal  = PH_W'(T_RP - 1);
      end
      ST_PRE: if (ph == '0) nxt = ST_IDLE;
      ST_RCAS: begin
        nxt    = ST_RRAS;
        phLoad = 1'b1;
        phVal  = PH_W'(T_RAS - 1);
      end
      ST_RRAS: if (ph == '0) begin
        nxt    = ST_PRE;
        phLoad = 1'b1;
        phVal  = PH_W'(T_RP - 1);
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign refFire = ready && (refTimer == REF_W'(REF_INT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_WAKE;
      ph       <= '0;
      wakeCnt  <= '0;
      refTimer <= '0;
      refsLeft <= RL_W'(WAKE_REFS);
      refPend  <= 1'b0;
    end else begin
      state <= nxt;
      if (phLoad)         ph <= phVal;
      else if (ph != '0)  ph <= ph - 1'b1;
      if (state == ST_WAKE) wakeCnt <= wakeCnt + 1'b1;
      if (ready) refTimer <= refFire ? '0 : refTimer + 1'b1;
      refPend <= refFire | (refPend & ~goRef);
      if (goRef && !ready) refsLeft <= refsLeft - 1'b1;
    end
  end

  assign rasN    = !(state == ST_ROW || state == ST_COL || state == ST_RRAS);
  assign ack     = (state == ST_ACK);
  assign weN     = !((state == ST_ROW || state == ST_COL) && opWrite);
  assign oeN     = !(state == ST_COL && !opWrite);
  assign dqDrive = (state == ST_ROW || state == ST_COL) && opWrite;

  always_comb begin
    stb.load    = goAcc;
    stb.selCol  = (state == ST_COL);
    stb.casOn   = (state == ST_COL);
    stb.casAll  = (state == ST_RCAS || state == ST_RRAS);
    stb.capture = (state == ST_COL) && (ph == '0) && !opWrite;
  end
endmodule

// File: rtl/fpdram_datapath.sv
module fpdram_datapath
  import fpdram_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dp_strobe_t           stb,
  input  logic                 hostWrite,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [DATA_W-1:0]    hostWdata,
  input  logic [DATA_W/8-1:0]  hostBe,
  input  logic [DATA_W-1:0]    dqIn,
  output logic                 opWrite,
  output logic [ADDR_W/2-1:0]  muxAddr,
  output logic [DATA_W/8-1:0]  casN,
  output logic [DATA_W-1:0]    dqOut,
  output logic [DATA_W-1:0]    rdata
);
  localparam int HALF  = ADDR_W / 2;
  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  beQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      dqOut   <= '0;
      beQ     <= '0;
      opWrite <= 1'b0;
    end else if (stb.load) begin
      addrQ   <= hostAddr;
      dqOut   <= hostWdata;
      beQ     <= hostBe;
      opWrite <= hostWrite;
    end
  end

  assign muxAddr = stb.selCol ? addrQ[HALF-1:0] : addrQ[ADDR_W-1:HALF];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign casN[g] = !(stb.casAll || (stb.casOn && beQ[g]));
    always_ff @(posedge clk) begin
      if (!rstN)            rdata[g*8 +: 8] <= '0;
      else if (stb.capture) rdata[g*8 +: 8] <= beQ[g] ? dqIn[g*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpdram_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int WAKE_CYC  = 20000,
  parameter int REF_INT   = 1560,
  parameter int WAKE_REFS = 8,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostReq,
  input  logic                 hostWrite,
  input  logic [ADDR_W-1:0]    hostAddr,
  input  logic [DATA_W-1:0]    hostWdata,
  input  logic [DATA_W/8-1:0]  hostBe,
  output logic                 hostAck,
  output logic [DATA_W-1:0]    hostRdata,
  output logic [ADDR_W/2-1:0]  dramAddr,
  output logic                 dramRasN,
  output logic [DATA_W/8-1:0]  dramCasN,
  output logic                 dramWeN,
  output logic                 dramOeN,
  output logic [DATA_W-1:0]    dramDqOut,
  input  logic [DATA_W-1:0]    dramDqIn,
  output logic                 dramDqDrive
);
  dp_strobe_t stb;
  logic       opWrite;

  fpdram_ctrl #(
    .WAKE_CYC(WAKE_CYC), .REF_INT(REF_INT), .WAKE_REFS(WAKE_REFS),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS(T_RAS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .opWrite(opWrite),
    .ack(hostAck), .rasN(dramRasN), .weN(dramWeN), .oeN(dramOeN),
    .dqDrive(dramDqDrive), .stb(stb)
  );

  fpdram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostBe(hostBe),
    .dqIn(dramDqIn), .opWrite(opWrite), .muxAddr(dramAddr),
    .casN(dramCasN), .dqOut(dramDqOut), .rdata(hostRdata)
  );
endmodule

// File: rtl/fpm_dram_chk.sv
module fpm_dram_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostAck,
  input logic             dramRasN,
  input logic [LANES-1:0] dramCasN,
  input logic             dramWeN,
  input logic             dramOeN,
  input logic             dramDqDrive
);
  // R6
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dramWeN |-> dramOeN);
  // R6
  early_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dramWeN && !(&dramCasN) && $past(&dramCasN)) |-> $past(!dramWeN));
  // R6
  drive_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    dramDqDrive |-> !dramWeN);
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |=> !hostAck);
  // R8
  ack_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> (dramRasN && (&dramCasN)));
  // R2
  cbr_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dramRasN && !(&dramCasN)) |-> (dramCasN == '0 && dramWeN && dramOeN));
  // R7
  oe_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dramOeN |-> !dramRasN);
endmodule

bind fpm_dram_ctrl fpm_dram_chk #(.LANES(DATA_W/8)) chk_i (
  .clk(clk), .rstN(rstN), .hostAck(hostAck), .dramRasN(dramRasN),
  .dramCasN(dramCasN), .dramWeN(dramWeN), .dramOeN(dramOeN),
  .dramDqDrive(dramDqDrive)
);

// File: tb/fpm_dram_ctrl_tb_top.sv
module fpm_dram_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAKE  = 40;
  localparam int RINT  = 100;
  localparam int NREF  = 8;
  localparam int RCD   = 2;
  localparam int CASW  = 2;
  localparam int RP    = 2;
  localparam int TRAS  = 3;
  localparam int K_IDLE = 0, K_WAIT = 1, K_REF = 2, K_RD = 3, K_WR = 4;

  logic clk = 0, rstN = 0;
  logic hostReq = 0, hostWrite = 0;
  logic [19:0] hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [1:0]  hostBe = '0;
  logic hostAck, dramRasN, dramWeN, dramOeN, dramDqDrive;
  logic [15:0] hostRdata, dramDqOut, dramDqIn;
  logic [9:0]  dramAddr;
  logic [1:0]  dramCasN;

  fpm_dram_ctrl #(.WAKE_CYC(WAKE), .REF_INT(RINT), .WAKE_REFS(NREF),
    .T_RCD(RCD), .T_CAS(CASW), .T_RP(RP), .T_RAS(TRAS)) dut_i (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostBe(hostBe),
    .hostAck(hostAck), .hostRdata(hostRdata), .dramAddr(dramAddr),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramOeN(dramOeN), .dramDqOut(dramDqOut), .dramDqIn(dramDqIn),
    .dramDqDrive(dramDqDrive));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFails = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mKind = K_WAIT, mAge = 0, mRefsLeft = NREF, mTimer = 0;
  bit mPend = 0, mWakeRef = 0;
  logic [19:0] mAddr = '0;
  logic [15:0] mData = '0, mExpRd = '0;
  logic [1:0]  mBe = '0;
  logic [15:0] shadow [int];
  int refOverReq = 0;

  function automatic int lenOf(int k);
    if (k == K_WAIT) return WAKE;
    if (k == K_REF)  return 1 + TRAS + RP;
    return RCD + CASW + 1 + RP;
  endfunction

  function automatic logic [15:0] laneMask(logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mKind = K_WAIT; mAge = 0; mRefsLeft = NREF; mTimer = 0; mPend = 0;
    end else begin
      bit fire, clr;
      fire = 0; clr = 0;
      if (mRefsLeft == 0) begin
        if (mTimer == RINT-1) begin mTimer = 0; fire = 1; end
        else mTimer++;
      end
      if (mKind == K_IDLE) begin
        if (mRefsLeft > 0 || mPend) begin
          mWakeRef = (mRefsLeft > 0);
          if (!mWakeRef && hostReq) refOverReq++;
          mKind = K_REF; mAge = 0; clr = 1;
          if (mRefsLeft > 0) mRefsLeft--;
        end else if (hostReq) begin
          logic [15:0] old;
          mKind = hostWrite ? K_WR : K_RD; mAge = 0;
          mAddr = hostAddr; mData = hostWdata; mBe = hostBe;
          old = shadow.exists(int'(hostAddr)) ? shadow[int'(hostAddr)] : 16'h0;
          if (hostWrite)
            shadow[int'(hostAddr)] = (old & ~laneMask(hostBe)) | (hostWdata & laneMask(hostBe));
          mExpRd = old & laneMask(hostBe);
        end
      end else begin
        mAge++;
        if (mAge == lenOf(mKind)) mKind = K_IDLE;
      end
      mPend = fire | (mPend & !clr);
    end
  end

  // ---------------- simple DRAM pin model ----------------
  logic [15:0] dmem [int];
  logic [9:0]  rowLatch = '0;
  logic        pRas = 1;
  logic [1:0]  pCas = 2'b11;
  int          cbrSeen = 0;
  bit          firstRow = 1;

  always @* begin
    logic [15:0] w;
    int key;
    dramDqIn = 16'hA5A5;
    if (!dramOeN && !dramRasN) begin
      key = int'({rowLatch, dramAddr});
      w = dmem.exists(key) ? dmem[key] : 16'h0;
      if (!dramCasN[0]) dramDqIn[7:0]  = w[7:0];
      if (!dramCasN[1]) dramDqIn[15:8] = w[15:8];
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (pRas && !dramRasN) begin
        if (dramCasN == 2'b00) cbrSeen++;
        else begin
          rowLatch = dramAddr;
          if (firstRow) begin
            // R1: wake-up refreshes done before the first row access
            chk(cbrSeen >= NREF, "R1 wake refreshes before access", cbrSeen, NREF);
            firstRow = 0;
          end
        end
      end
      if (!dramRasN && !dramWeN && (pCas & ~dramCasN) != 2'b00) begin
        int key;
        logic [15:0] w;
        key = int'({rowLatch, dramAddr});
        w = dmem.exists(key) ? dmem[key] : 16'h0;
        if (pCas[0] && !dramCasN[0]) w[7:0]  = dramDqOut[7:0];
        if (pCas[1] && !dramCasN[1]) w[15:8] = dramDqOut[15:8];
        dmem[key] = w;
      end
      pRas = dramRasN; pCas = dramCasN;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    logic eRas, eWe, eOe, eAck;
    logic [1:0] eCas;
    string tag;
    if (!rstN) begin
      // R1: reset state
      chk({dramRasN, dramCasN, dramWeN, dramOeN, hostAck} == 6'b111110,
          "R1 reset strobes", {dramRasN, dramCasN, dramWeN, dramOeN, hostAck}, 6'b111110);
    end else begin
      eRas = 1; eCas = 2'b11; eWe = 1; eOe = 1; eAck = 0; tag = "R1 idle/wake strobes";
      if (mKind == K_REF) begin
        tag = mWakeRef ? "R1,R2 wake refresh" : "R2,R3 periodic refresh";
        if (mAge == 0) eCas = 2'b00;
        else if (mAge <= TRAS) begin eRas = 0; eCas = 2'b00; end
      end else if (mKind == K_RD || mKind == K_WR) begin
        tag = (mKind == K_WR) ? "R4,R5,R6,R8 write strobes" : "R4,R5,R7,R8 read strobes";
        if (mAge < RCD + CASW) begin
          eRas = 0;
          eWe  = (mKind != K_WR);
          if (mAge >= RCD) begin
            eCas = ~mBe;
            eOe  = (mKind == K_WR);
          end
        end else if (mAge == RCD + CASW) eAck = 1;
        if (mAge < RCD)
          chk(dramAddr == mAddr[19:10], "R4,R9 row address", dramAddr, mAddr[19:10]);
        else if (mAge < RCD + CASW)
          chk(dramAddr == mAddr[9:0], "R4,R9 column address", dramAddr, mAddr[9:0]);
        if (mKind == K_WR && mAge < RCD + CASW)
          chk(dramDqDrive && dramDqOut == mData, "R6,R9 write data",
              {dramDqDrive, dramDqOut}, {1'b1, mData});
        if (mKind == K_RD && mAge == RCD + CASW)
          chk(hostRdata == mExpRd, "R7,R9 read data", hostRdata, mExpRd);
      end
      chk({dramRasN, dramCasN, dramWeN, dramOeN, hostAck} == {eRas, eCas, eWe, eOe, eAck},
          tag, {dramRasN, dramCasN, dramWeN, dramOeN, hostAck}, {eRas, eCas, eWe, eOe, eAck});
    end
  end

  // ---------------- stimulus ----------------
  task automatic doOp(input bit wr, input logic [19:0] a, input logic [15:0] d,
                      input logic [1:0] be, input bit scramble);
    hostReq = 1; hostWrite = wr; hostAddr = a; hostWdata = d; hostBe = be;
    do begin
      @(negedge clk);
      if (scramble && (mKind == K_RD || mKind == K_WR)) begin
        hostAddr = 20'($urandom); hostWdata = 16'($urandom);
        hostBe = 2'($urandom); hostWrite = 1'($urandom);
      end
    end while (!hostAck);
    hostReq = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    // requests made during the wake-up phase must wait (R1)
    doOp(1, 20'h00000, 16'h1234, 2'b11, 0);
    doOp(1, 20'hFFFFF, 16'hABCD, 2'b11, 0);
    doOp(0, 20'h00000, 16'h0000, 2'b11, 0);
    doOp(0, 20'hFFFFF, 16'h0000, 2'b11, 0);
    // R5: byte-lane merges
    doOp(1, 20'h12345, 16'h55AA, 2'b01, 0);
    doOp(1, 20'h12345, 16'h9966, 2'b10, 0);
    doOp(0, 20'h12345, 16'h0000, 2'b11, 0);
    doOp(0, 20'h12345, 16'h0000, 2'b01, 0);
    doOp(0, 20'h12345, 16'h0000, 2'b10, 0);
    doOp(1, 20'h12345, 16'hFFFF, 2'b00, 0);
    doOp(0, 20'h12345, 16'h0000, 2'b11, 0);
    // R9: inputs scrambled while busy
    for (int i = 0; i < 60; i++) begin
      logic [19:0] a;
      a = {8'h3C, 2'(i % 4), 8'h00, 2'(i % 3)};
      doOp(1'($urandom), a, 16'($urandom), 2'($urandom), i[0]);
      repeat ($urandom % 6) @(negedge clk);
    end
    repeat (RINT + 20) @(negedge clk);
    // R3: a pending refresh was seen to win over a waiting request
    chk(refOverReq > 0, "R3 refresh ahead of request", refOverReq, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule